// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block runs a 32-pin general-purpose I/O port from a plain memory-mapped register bus with single-cycle reads and writes. It has no direction register. A pin becomes a driven output when software writes a 1 for it into the raise or lower register. It goes back to being undriven when software writes a 1 for it into the float register. A bit written as 0 leaves its pin as it was. Software can therefore change single pins without a read-modify-write sequence.

Every pin input goes through a two-stage synchroniser and then into a pin-state register. That register reads as zero until software arms input sampling by writing any value to the pin-state offset. A small two-state machine holds the arm: `IEN_GATED` moves to `IEN_OPEN` on the transition *arm-write*. `IEN_OPEN` has no exit except reset. Address decoding turns each bus cycle into one write operation (`WOP_IDLE`, `WOP_FLOAT`, `WOP_SET`, `WOP_CLR`, `WOP_ARM`) and one read selection (`RSEL_NONE`, `RSEL_FLOAT`, `RSEL_LATCH`, `RSEL_PIN`). Read data is registered.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, every pin is undriven (`pin_oe` = 0), the output latch is 0, `bus_rdata` is 0, and a read of the float register (offset 0x100) returns all ones.
- R2: A write to offset 0x108 sets the output latch and the output enable for each bit written as 1, starting the cycle after the write. Bits written as 0 keep their latch and enable values.
- R3: A write to offset 0x10C clears the output latch and sets the output enable for each bit written as 1, starting the cycle after the write. This also applies to a pin that was undriven. Bits written as 0 are unchanged.
- R4: A write to offset 0x100 clears the output enable for each bit written as 1 and leaves the output latch unchanged.
- R5: A read at offset 0x100 returns the float state (1 = undriven), which is the inverse of `pin_oe`. A read at offset 0x108 returns the output latch.
- R6: Until input sampling is armed, a read at offset 0x110 returns 0 whatever the pin levels are.
- R7: A write to offset 0x110 with any data, zero included, arms input sampling. It stays armed until reset, and later writes to 0x110 have no further effect.
- R8: Once sampling is armed, a level change on `pin_in` reaches the pin-state register through three register stages. A read whose strobe is sampled at the third clock edge after the change still returns the old value. A read at the fourth edge returns the new value.
- R9: A write to any other address changes no state, and a read of any other address returns 0.
- R10: `bus_rdata` changes only on a clock edge where `bus_rd` is high. It then shows the register value as it was before that edge, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data; each bit selects one pin |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables, 1 = driven |
| pin_in | input | 32 | Asynchronous pad levels |

## Verification
The bench checks that zero bits in the raise, lower and float writes leave their pins alone. A design that wrote the whole latch would lose pins it was never told to change. It checks that a lower write drives a pin that was floating, and that an arm write carrying zero data still opens sampling. A design that got either wrong would leave the pin undriven or the inputs permanently gated. It times back-to-back reads against an input change to pin the latency at exactly three stages, and it checks that writes to an unmapped address touch nothing. Finally it resets mid-run to confirm that sampling is gated again.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    // Write operation decoded from one bus cycle
    typedef enum logic [2:0] {
        WOP_IDLE,
        WOP_FLOAT,
        WOP_SET,
        WOP_CLR,
        WOP_ARM
    } wop_e;

    // Read source decoded from one bus cycle
    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_FLOAT,
        RSEL_LATCH,
        RSEL_PIN
    } rsel_e;

    // Input-enable controller states
    typedef enum logic {
        IEN_GATED,
        IEN_OPEN
    } ien_state_e;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFS_FLOAT = 'h100,
    parameter logic [ADDR_W-1:0] OFS_SET   = 'h108,
    parameter logic [ADDR_W-1:0] OFS_CLR   = 'h10C,
    parameter logic [ADDR_W-1:0] OFS_PIN   = 'h110
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output wop_e              wop,
    output rsel_e             rsel
);

    always_comb begin
        wop = WOP_IDLE;
        if (wr) begin
            if (addr == OFS_FLOAT)    wop = WOP_FLOAT;
            else if (addr == OFS_SET) wop = WOP_SET;
            else if (addr == OFS_CLR) wop = WOP_CLR;
            else if (addr == OFS_PIN) wop = WOP_ARM;
            else                      wop = WOP_IDLE;
        end
    end

    always_comb begin
        rsel = RSEL_NONE;
        if (rd) begin
            if (addr == OFS_FLOAT)    rsel = RSEL_FLOAT;
            else if (addr == OFS_SET) rsel = RSEL_LATCH;
            else if (addr == OFS_PIN) rsel = RSEL_PIN;
            else                      rsel = RSEL_NONE;
        end
    end

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_sc_ien_fsm.sv
module gpio_sc_ien_fsm
    import gpio_sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ien
);

    ien_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IEN_GATED: if (arm) state_d = IEN_OPEN;
            IEN_OPEN:  state_d = IEN_OPEN;
            default:   state_d = IEN_GATED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IEN_GATED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IEN_OPEN: ien = 1'b1;
            default:  ien = 1'b0;
        endcase
    end

    // R7: once open, sampling never closes again before reset
    p_ien_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ien |=> ien);

    // R7: an arm request opens sampling on the next cycle
    p_ien_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> ien);

endmodule

// File: rtl/gpio_sc_drive.sv
module gpio_sc_drive
    import gpio_sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wop_e             wop,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] float_q
);

    logic [WIDTH-1:0] out_d, float_d;

    always_comb begin
        out_d   = out_q;
        float_d = float_q;
        unique case (wop)
            WOP_FLOAT: float_d = float_q | mask;
            WOP_SET: begin
                out_d   = out_q | mask;
                float_d = float_q & ~mask;
            end
            WOP_CLR: begin
                out_d   = out_q & ~mask;
                float_d = float_q & ~mask;
            end
            WOP_IDLE, WOP_ARM: begin
                out_d   = out_q;
                float_d = float_q;
            end
            default: begin
                out_d   = out_q;
                float_d = float_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            float_q <= '1;
        end else begin
            out_q   <= out_d;
            float_q <= float_d;
        end
    end

    // R2: raised pins are high and driven after the write
    p_set_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_SET) |=> (((out_q & $past(mask)) == $past(mask)) &&
                              ((float_q & $past(mask)) == '0)));

    // R2: zero bits of a raise write keep their latch value
    p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_SET) |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));

    // R3: lowered pins are low and driven after the write
    p_clr_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_CLR) |=> (((out_q & $past(mask)) == '0) &&
                              ((float_q & $past(mask)) == '0)));

    // R4: a float write releases pins and leaves the latch alone
    p_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wop == WOP_FLOAT) |=> ($stable(out_q) &&
                                ((float_q & $past(mask)) == $past(mask))));

    // R9: cycles with no drive operation change no drive state
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((wop == WOP_IDLE) || (wop == WOP_ARM)) |=> ($stable(out_q) && $stable(float_q)));

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PINS        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [PINS-1:0]   bus_rdata,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    input  logic [PINS-1:0]   pin_in
);

    localparam logic [ADDR_W-1:0] OFS_FLOAT = ADDR_W'('h100);
    localparam logic [ADDR_W-1:0] OFS_SET   = ADDR_W'('h108);
    localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'('h10C);
    localparam logic [ADDR_W-1:0] OFS_PIN   = ADDR_W'('h110);

    wop_e            wop;
    rsel_e           rsel;
    logic            ien;
    logic [PINS-1:0] out_q, float_q, synced, pin_q, rd_mux;

    gpio_sc_decode #(
        .ADDR_W   (ADDR_W),
        .OFS_FLOAT(OFS_FLOAT),
        .OFS_SET  (OFS_SET),
        .OFS_CLR  (OFS_CLR),
        .OFS_PIN  (OFS_PIN)
    ) u_decode (
        .addr(bus_addr),
        .wr  (bus_wr),
        .rd  (bus_rd),
        .wop (wop),
        .rsel(rsel)
    );

    gpio_sc_drive #(.WIDTH(PINS)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .wop    (wop),
        .mask   (bus_wdata),
        .out_q  (out_q),
        .float_q(float_q)
    );

    gpio_sc_ien_fsm u_ien (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (wop == WOP_ARM),
        .ien  (ien)
    );

    gpio_sc_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (synced)
    );

    // pin-state register, forced to zero while sampling is gated
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pin_q <= '0;
        else if (ien) pin_q <= synced;
        else          pin_q <= '0;
    end

    always_comb begin
        unique case (rsel)
            RSEL_FLOAT: rd_mux = float_q;
            RSEL_LATCH: rd_mux = out_q;
            RSEL_PIN:   rd_mux = pin_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign pin_out = out_q;
    assign pin_oe  = ~float_q;

    // R6: while gated, the pin-state register stays zero
    p_gated_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |=> (pin_q == '0));

    // R10: read data moves only on a read strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9: reads of unmapped addresses return zero
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (rsel == RSEL_NONE)) |=> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_sc_port.sv
`timescale 1ns/1ps
module test_gpio_sc_port;

    localparam logic [11:0] A_FLOAT = 12'h100;
    localparam logic [11:0] A_SET   = 12'h108;
    localparam logic [11:0] A_CLR   = 12'h10C;
    localparam logic [11:0] A_PIN   = 12'h110;
    localparam logic [11:0] A_HOLE  = 12'h104;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata, pin_out, pin_oe;
    logic [31:0] pin_in = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        done = 1'b0;

    always #2 clk = ~clk;

    gpio_sc_port i_gpio_sc_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue a read and queue its expected result
    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compare read data after each strobed edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd && rst_n) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(bus_rdata, 32'hx, "R10 unexpected read");
                end else begin
                    chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pin_oe,    32'h0, "R1 oe after reset");
        chk(pin_out,   32'h0, "R1 latch after reset");
        chk(bus_rdata, 32'h0, "R1 rdata after reset");
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(A_FLOAT, 32'hFFFF_FFFF, "R1 float all ones");
        bus_read(A_SET,   32'h0,         "R5 latch zero");

        bus_write(A_SET, 32'h0000_00F0);
        chk(pin_out, 32'h0000_00F0, "R2 raise latch");
        chk(pin_oe,  32'h0000_00F0, "R2 raise oe");
        bus_write(A_SET, 32'h0000_0F00);
        chk(pin_out, 32'h0000_0FF0, "R2 zero bits kept");
        chk(pin_oe,  32'h0000_0FF0, "R2 zero bits oe kept");

        bus_write(A_CLR, 32'h0000_0030);
        chk(pin_out, 32'h0000_0FC0, "R3 lower latch");
        chk(pin_oe,  32'h0000_0FF0, "R3 lower oe");
        bus_write(A_CLR, 32'h8000_0000);
        chk(pin_out, 32'h0000_0FC0, "R3 lower floating pin latch");
        chk(pin_oe,  32'h8000_0FF0, "R3 lower floating pin drives");

        bus_write(A_FLOAT, 32'h0000_0F00);
        chk(pin_oe,  32'h8000_00F0, "R4 float oe");
        chk(pin_out, 32'h0000_0FC0, "R4 latch unchanged");
        bus_read(A_FLOAT, 32'h7FFF_FF0F, "R5 float readback");
        bus_read(A_SET,   32'h0000_0FC0, "R5 latch readback");

        pin_in = 32'hA5A5_5A5A;
        repeat (4) @(negedge clk);
        bus_read(A_PIN, 32'h0, "R6 gated pin state");

        bus_write(A_HOLE, 32'hFFFF_FFFF);
        chk(pin_oe,  32'h8000_00F0, "R9 hole write oe");
        chk(pin_out, 32'h0000_0FC0, "R9 hole write latch");
        bus_read(A_HOLE, 32'h0, "R9 hole read");
        bus_read(A_CLR,  32'h0, "R9 write-only read");

        bus_write(A_PIN, 32'h0);
        repeat (2) @(negedge clk);
        bus_read(A_PIN, 32'hA5A5_5A5A, "R7 armed by zero write");

        pin_in = 32'h1234_5678;
        bus_read(A_PIN, 32'hA5A5_5A5A, "R8 edge1 old");
        bus_read(A_PIN, 32'hA5A5_5A5A, "R8 edge2 old");
        bus_read(A_PIN, 32'hA5A5_5A5A, "R8 edge3 old");
        bus_read(A_PIN, 32'h1234_5678, "R8 edge4 new");
        repeat (3) @(negedge clk);
        chk(bus_rdata, 32'h1234_5678, "R10 rdata holds");
        bus_write(A_SET, 32'h0000_0001);
        chk(bus_rdata, 32'h1234_5678, "R10 rdata holds over write");

        bus_write(A_PIN, 32'hFFFF_FFFF);
        pin_in = 32'h0F0F_0F0F;
        repeat (4) @(negedge clk);
        bus_read(A_PIN, 32'h0F0F_0F0F, "R7 still armed");

        rst_n = 1'b0;
        @(negedge clk);
        chk(pin_oe,  32'h0, "R1 oe after second reset");
        chk(pin_out, 32'h0, "R1 latch after second reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(A_PIN, 32'h0, "R6 gated again after reset");

        repeat (2) @(negedge clk);
        chk(exp_q.size(), 32'h0, "R10 all reads answered");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule